// File: doc/BRIEF.md
# Byte-Wide Many-Time-Programmable Flash Controller

This block models the control side of a byte-wide flash array that is rewritten only by an external programmer. It holds its own storage array. Active-low chip-select, output-enable and write-strobe inputs pick the operating mode, together with two digital flags. The flags stand for a high voltage applied to the output-enable pin and to address bit 9. The block serves array reads and a two-byte identification readout. It performs byte programming and whole-array erase, and it times both operations with cycle counters derived from a clock-frequency parameter.

Programming can only clear bits: the stored byte becomes the old byte ANDed with the presented byte. Only an erase can return bits to 1, and it does so for every byte at once. While an operation runs, a busy output is high and further write strobes are ignored. If a qualifying high-voltage flag drops before the operation completes, the operation is abandoned and a sticky error flag is set. The flag stays set until reset.

The logical address bus is `BUS_AW` bits wide, from 16 to 19 bits. Only the low `STORE_AW` bits index the storage, so the stored image repeats across the address space.

Top module: `mtp_flash_ctrl`

## Requirements
- R1: `data_drive` is high only when `chip_sel_n`=0, `out_en_n`=0 and `hv_ctl`=0, and not when `hv_sel`=1 with `wr_strb_n`=0. In every other case it is low and the bus is released.
- R2: After reset, `busy`=0, `err`=0 and `data_drive`=0 while `chip_sel_n`=1. Reset does not alter the stored bytes.
- R3: A byte program starts at a falling edge of `wr_strb_n` sampled while `chip_sel_n`=0, `hv_ctl`=1 and `hv_sel`=0. The address and data are latched at that edge. `busy` is high for exactly `CLK_MHZ*PROG_US` cycles, starting the cycle after the edge. The byte is written as that run ends.
- R4: A program stores the old byte ANDed with the input byte, so no bit ever goes from 0 to 1 through programming.
- R5: A chip erase starts at a falling edge of `wr_strb_n` sampled while `chip_sel_n`=0, `hv_ctl`=1 and `hv_sel`=1. `busy` stays high for max(`CLK_MHZ*ERASE_US`, 2^`STORE_AW`) cycles. Afterwards every byte reads FFh. Address and data inputs have no effect on an erase.
- R6: With `chip_sel_n`=0, `out_en_n`=0, `wr_strb_n`=1, `hv_ctl`=0 and `hv_sel`=1, the bus is driven with identification data. The value is BFh when the address is 0 and the device code when the address is 1. Any other address gives 00h. The device code is C4h, C5h, C6h or C2h for `BUS_AW` = 16, 17, 18 or 19.
- R7: No operation starts without a qualifying falling edge of `wr_strb_n`. A strobe with `chip_sel_n`=1, or with `hv_ctl`=0, leaves `busy` low and the stored bytes unchanged.
- R8: Falling edges of `wr_strb_n` while `busy` is high start nothing and do not lengthen the busy period.
- R9: If `hv_ctl` (for a program), or `hv_ctl` or `hv_sel` (for an erase), is low at any edge while busy, the operation is abandoned. In that case `busy` falls and `err` rises at that edge, and a pending program writes nothing. This holds even at the edge that would have completed the program. `err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chip_sel_n | input | 1 | Active-low chip select |
| out_en_n | input | 1 | Active-low output enable |
| wr_strb_n | input | 1 | Active-low write strobe |
| hv_ctl | input | 1 | High-voltage flag on the output-enable pin |
| hv_sel | input | 1 | High-voltage flag on address bit 9 |
| addr | input | BUS_AW | Byte address |
| data_in | input | 8 | Byte presented for programming |
| data_out | output | 8 | Read or identification byte |
| data_drive | output | 1 | High when `data_out` is driven onto the bus |
| busy | output | 1 | Program or erase in progress |
| err | output | 1 | Sticky flag for an abandoned operation |

## Verification
Two events can fall on the same clock edge: a program reaching its final count, and the loss of its high-voltage qualifier. The bench starts a program and counts busy cycles. It then drops `hv_ctl` exactly at the last busy cycle, so the abort and the completion are decided at one edge. Abort must win: the byte must still read FFh and `err` must be set. A second same-edge case is a new write strobe arriving while busy. Here the bench checks that the busy run keeps its length and that the second address stays erased.

// File: rtl/mtp_flash_pkg.sv
package mtp_flash_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_QUIET,
    MODE_READ,
    MODE_IDENT,
    MODE_PROG,
    MODE_ERASE
  } mode_e;

  typedef enum logic [1:0] {
    OP_IDLE,
    OP_PROG,
    OP_ERASE
  } op_e;

  localparam logic [7:0] MAKER_CODE = 8'hBF;

  function automatic logic [7:0] part_code(input int bus_aw);
    case (bus_aw)
      16:      part_code = 8'hC4;
      17:      part_code = 8'hC5;
      18:      part_code = 8'hC6;
      default: part_code = 8'hC2;
    endcase
  endfunction

endpackage

// File: rtl/mtp_mode_dec.sv
module mtp_mode_dec
  import mtp_flash_pkg::*;
(
  input  logic  chip_sel_n,
  input  logic  out_en_n,
  input  logic  wr_strb_n,
  input  logic  hv_ctl,
  input  logic  hv_sel,
  output mode_e mode
);

  always_comb begin
    if (chip_sel_n)        mode = MODE_STANDBY;
    else if (hv_ctl)       mode = hv_sel ? MODE_ERASE : MODE_PROG;
    else if (out_en_n)     mode = MODE_QUIET;
    else if (hv_sel)       mode = wr_strb_n ? MODE_IDENT : MODE_QUIET;
    else                   mode = MODE_READ;
  end

endmodule

// File: rtl/mtp_op_seq.sv
module mtp_op_seq
  import mtp_flash_pkg::*;
#(
  parameter int AW        = 10,
  parameter int PROG_CYC  = 500,
  parameter int ERASE_CYC = 5000,
  parameter int CNT_W     = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_prog,
  input  logic          start_erase,
  input  logic          hold_prog,
  input  logic          hold_erase,
  input  logic [AW-1:0] addr_in,
  input  logic [7:0]    data_in,
  output logic          busy,
  output logic          err,
  output logic          prog_we,
  output logic [AW-1:0] prog_addr,
  output logic [7:0]    prog_data,
  output logic          sweep_we,
  output logic [AW-1:0] sweep_addr
);

  localparam int DEPTH = 1 << AW;
  localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] SWEEP_END  = CNT_W'(DEPTH);

  op_e              state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;
  logic [AW-1:0]    addr_q;
  logic [7:0]       data_q;
  logic             latch_en;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    err_d    = err_q;
    latch_en = 1'b0;
    prog_we  = 1'b0;
    sweep_we = 1'b0;
    case (state_q)
      OP_IDLE: begin
        cnt_d = '0;
        if (start_erase) begin
          state_d = OP_ERASE;
        end else if (start_prog) begin
          state_d  = OP_PROG;
          latch_en = 1'b1;
        end
      end
      OP_PROG: begin
        if (!hold_prog) begin
          state_d = OP_IDLE;
          err_d   = 1'b1;
        end else if (cnt_q == PROG_LAST) begin
          prog_we = 1'b1;
          state_d = OP_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      OP_ERASE: begin
        if (!hold_erase) begin
          state_d = OP_IDLE;
          err_d   = 1'b1;
        end else begin
          sweep_we = (cnt_q < SWEEP_END);
          if (cnt_q == ERASE_LAST) state_d = OP_IDLE;
          else                     cnt_d   = cnt_q + 1'b1;
        end
      end
      default: state_d = OP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= OP_IDLE;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (latch_en) begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end

  assign busy       = (state_q != OP_IDLE);
  assign err        = err_q;
  assign prog_addr  = addr_q;
  assign prog_data  = data_q;
  assign sweep_addr = cnt_q[AW-1:0];

endmodule

// File: rtl/mtp_cell_array.sv
module mtp_cell_array #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          prog_we,
  input  logic [AW-1:0] prog_addr,
  input  logic [7:0]    prog_data,
  input  logic          sweep_we,
  input  logic [AW-1:0] sweep_addr,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (sweep_we)     cells[sweep_addr] <= 8'hFF;
    else if (prog_we) cells[prog_addr]  <= cells[prog_addr] & prog_data;
  end

  assign rd_data = cells[rd_addr];

endmodule

// File: rtl/mtp_flash_ctrl.sv
module mtp_flash_ctrl
  import mtp_flash_pkg::*;
#(
  parameter int BUS_AW   = 16,
  parameter int STORE_AW = 10,
  parameter int CLK_MHZ  = 50,
  parameter int PROG_US  = 10,
  parameter int ERASE_US = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel_n,
  input  logic              out_en_n,
  input  logic              wr_strb_n,
  input  logic              hv_ctl,
  input  logic              hv_sel,
  input  logic [BUS_AW-1:0] addr,
  input  logic [7:0]        data_in,
  output logic [7:0]        data_out,
  output logic              data_drive,
  output logic              busy,
  output logic              err
);

  localparam int DEPTH     = 1 << STORE_AW;
  localparam int PROG_CYC  = CLK_MHZ * PROG_US;
  localparam int ERASE_RAW = CLK_MHZ * ERASE_US;
  localparam int ERASE_CYC = (ERASE_RAW < DEPTH) ? DEPTH : ERASE_RAW;
  localparam int MAX_CYC   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC) + 1;
  localparam logic [7:0] DEV_CODE = part_code(BUS_AW);

  logic       rst_meta_q, rst_sync_q;
  logic       strb_q;
  logic       strb_fall;
  mode_e      mode;
  logic       start_prog, start_erase;
  logic       prog_we, sweep_we;
  logic [STORE_AW-1:0] prog_addr, sweep_addr;
  logic [7:0] prog_data, cell_rd;
  logic [7:0] ident_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) strb_q <= 1'b1;
    else             strb_q <= wr_strb_n;
  end

  assign strb_fall = strb_q & ~wr_strb_n;

  mtp_mode_dec u_dec (
    .chip_sel_n (chip_sel_n),
    .out_en_n   (out_en_n),
    .wr_strb_n  (wr_strb_n),
    .hv_ctl     (hv_ctl),
    .hv_sel     (hv_sel),
    .mode       (mode)
  );

  assign start_prog  = strb_fall && (mode == MODE_PROG);
  assign start_erase = strb_fall && (mode == MODE_ERASE);

  mtp_op_seq #(
    .AW        (STORE_AW),
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC),
    .CNT_W     (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .start_prog  (start_prog),
    .start_erase (start_erase),
    .hold_prog   (hv_ctl),
    .hold_erase  (hv_ctl & hv_sel),
    .addr_in     (addr[STORE_AW-1:0]),
    .data_in     (data_in),
    .busy        (busy),
    .err         (err),
    .prog_we     (prog_we),
    .prog_addr   (prog_addr),
    .prog_data   (prog_data),
    .sweep_we    (sweep_we),
    .sweep_addr  (sweep_addr)
  );

  mtp_cell_array #(
    .AW (STORE_AW)
  ) u_array (
    .clk        (clk),
    .prog_we    (prog_we),
    .prog_addr  (prog_addr),
    .prog_data  (prog_data),
    .sweep_we   (sweep_we),
    .sweep_addr (sweep_addr),
    .rd_addr    (addr[STORE_AW-1:0]),
    .rd_data    (cell_rd)
  );

  always_comb begin
    if (addr[BUS_AW-1:1] != '0) ident_byte = 8'h00;
    else if (addr[0])           ident_byte = DEV_CODE;
    else                        ident_byte = MAKER_CODE;
  end

  assign data_drive = (mode == MODE_READ) || (mode == MODE_IDENT);
  assign data_out   = (mode == MODE_IDENT) ? ident_byte : cell_rd;

endmodule

// File: rtl/mtp_flash_ctrl_chk.sv
module mtp_flash_ctrl_chk #(
  parameter int BUS_AW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_sel_n,
  input logic              out_en_n,
  input logic              wr_strb_n,
  input logic              hv_ctl,
  input logic              hv_sel,
  input logic [BUS_AW-1:0] addr,
  input logic [7:0]        data_out,
  input logic              data_drive,
  input logic              busy,
  input logic              err
);

  // R1
  drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_drive |-> (!chip_sel_n && !out_en_n && !hv_ctl));

  // R6
  maker_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_sel_n && !out_en_n && wr_strb_n && !hv_ctl && hv_sel && addr == '0)
      |-> (data_drive && data_out == 8'hBF));

  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!chip_sel_n && !wr_strb_n && hv_ctl));

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> ($past(busy) && !busy && $past(!hv_ctl || !hv_sel)));

endmodule

bind mtp_flash_ctrl mtp_flash_ctrl_chk #(.BUS_AW(BUS_AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chip_sel_n (chip_sel_n),
  .out_en_n   (out_en_n),
  .wr_strb_n  (wr_strb_n),
  .hv_ctl     (hv_ctl),
  .hv_sel     (hv_sel),
  .addr       (addr),
  .data_out   (data_out),
  .data_drive (data_drive),
  .busy       (busy),
  .err        (err)
);

// File: tb/mtp_flash_ctrl_bench.sv
module mtp_flash_ctrl_bench;

  localparam int BUS_AW   = 17;
  localparam int STORE_AW = 6;
  localparam int CLK_MHZ  = 50;
  localparam int PROG_US  = 1;
  localparam int ERASE_US = 30;
  localparam int PROG_N   = CLK_MHZ * PROG_US;
  localparam int ERASE_N  = CLK_MHZ * ERASE_US;
  localparam int NVEC     = 6;
  // {addr[15:0], data[7:0], expected[7:0]}
  localparam logic [31:0] VEC [NVEC] = '{
    {16'h0005, 8'hA5, 8'hA5},
    {16'h0005, 8'h0F, 8'h05},
    {16'h0005, 8'hFF, 8'h05},
    {16'h003F, 8'h00, 8'h00},
    {16'h0010, 8'h3C, 8'h3C},
    {16'h0011, 8'hC3, 8'hC3}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              chip_sel_n, out_en_n, wr_strb_n, hv_ctl, hv_sel;
  logic [BUS_AW-1:0] addr;
  logic [7:0]        data_in;
  logic [7:0]        data_out;
  logic              data_drive, busy, err;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  mtp_flash_ctrl #(
    .BUS_AW (BUS_AW), .STORE_AW (STORE_AW), .CLK_MHZ (CLK_MHZ),
    .PROG_US (PROG_US), .ERASE_US (ERASE_US)
  ) u_mtp_flash_ctrl (
    .clk (clk), .rst_n (rst_n), .chip_sel_n (chip_sel_n), .out_en_n (out_en_n),
    .wr_strb_n (wr_strb_n), .hv_ctl (hv_ctl), .hv_sel (hv_sel), .addr (addr),
    .data_in (data_in), .data_out (data_out), .data_drive (data_drive),
    .busy (busy), .err (err)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    chip_sel_n = 1'b1; out_en_n = 1'b1; wr_strb_n = 1'b1;
    hv_ctl = 1'b0; hv_sel = 1'b0; addr = '0; data_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // drives one write-strobe pulse; returns at the negedge after the falling edge was sampled
  task automatic strobe(input logic sel_n, input logic hvc, input logic hvs,
                        input logic [BUS_AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    chip_sel_n = sel_n; out_en_n = 1'b1; hv_ctl = hvc; hv_sel = hvs;
    addr = a; data_in = d; wr_strb_n = 1'b0;
    @(negedge clk);
    wr_strb_n = 1'b1;
  endtask

  task automatic count_busy(inout int n);
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic rd(input logic [BUS_AW-1:0] a, input logic ident,
                    output logic [7:0] q, output logic drv);
    @(negedge clk);
    chip_sel_n = 1'b0; out_en_n = 1'b0; wr_strb_n = 1'b1;
    hv_ctl = 1'b0; hv_sel = ident; addr = a;
    #2;
    q = data_out; drv = data_drive;
  endtask

  task automatic idle_pins();
    @(negedge clk);
    chip_sel_n = 1'b1; out_en_n = 1'b1; wr_strb_n = 1'b1;
    hv_ctl = 1'b0; hv_sel = 1'b0;
  endtask

  task automatic full_erase(output int n);
    n = 0;
    strobe(1'b0, 1'b1, 1'b1, '0, 8'h00);
    while (busy) begin
      n++;
      @(negedge clk);
      addr = addr + 17'd3;           // R5: address and data must not matter
      data_in = data_in + 8'h11;
    end
    idle_pins();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int         n;
    int         bad;
    logic [7:0] q;
    logic       drv;

    do_reset();
    // R2 reset state
    chk(busy == 1'b0, "R2 busy", busy, 0);
    chk(err == 1'b0, "R2 err", err, 0);
    chk(data_drive == 1'b0, "R2 drive", data_drive, 0);

    // R5 erase timing and content
    full_erase(n);
    chk(n == ERASE_N, "R5 erase busy length", n, ERASE_N);
    chk(err == 1'b0, "R5 no error", err, 0);
    bad = 0;
    for (int i = 0; i < (1 << STORE_AW); i++) begin
      rd(BUS_AW'(i), 1'b0, q, drv);
      if (q != 8'hFF || !drv) bad++;
    end
    chk(bad == 0, "R5 all bytes FF", bad, 0);

    // R6 identification
    rd(17'h00000, 1'b1, q, drv);
    chk(drv && q == 8'hBF, "R6 maker code", q, 8'hBF);
    rd(17'h00001, 1'b1, q, drv);
    chk(drv && q == 8'hC5, "R6 device code", q, 8'hC5);
    rd(17'h00100, 1'b1, q, drv);
    chk(drv && q == 8'h00, "R6 other address", q, 8'h00);

    // R1 bus release cases
    @(negedge clk);
    chip_sel_n = 1'b1; out_en_n = 1'b0; hv_ctl = 1'b0; hv_sel = 1'b0; #2;
    chk(!data_drive, "R1 chip deselected", data_drive, 0);
    @(negedge clk);
    chip_sel_n = 1'b0; out_en_n = 1'b1; #2;
    chk(!data_drive, "R1 output disabled", data_drive, 0);
    @(negedge clk);
    out_en_n = 1'b0; hv_ctl = 1'b1; #2;
    chk(!data_drive, "R1 high voltage on enable", data_drive, 0);
    @(negedge clk);
    hv_ctl = 1'b0; #2;
    chk(data_drive, "R1 read drives", data_drive, 1);
    idle_pins();

    // R3 / R4 vector table
    for (int v = 0; v < NVEC; v++) begin
      n = 0;
      strobe(1'b0, 1'b1, 1'b0, BUS_AW'(VEC[v][31:16]), VEC[v][15:8]);
      count_busy(n);
      chk(n == PROG_N, "R3 program busy length", n, PROG_N);
      idle_pins();
      rd(BUS_AW'(VEC[v][31:16]), 1'b0, q, drv);
      chk(q == VEC[v][7:0], "R3 R4 programmed byte", q, VEC[v][7:0]);
    end
    // R4 aliasing through upper bus bits reads the same cell
    rd(17'h10005, 1'b0, q, drv);
    chk(q == 8'h05, "R4 aliased read", q, 8'h05);

    // R7 strobes that must not start anything
    strobe(1'b1, 1'b1, 1'b0, 17'h20, 8'h00);
    repeat (3) @(negedge clk);
    chk(!busy, "R7 deselected strobe busy", busy, 0);
    strobe(1'b0, 1'b0, 1'b0, 17'h21, 8'h00);
    repeat (3) @(negedge clk);
    chk(!busy, "R7 no high voltage busy", busy, 0);
    idle_pins();
    rd(17'h20, 1'b0, q, drv);
    chk(q == 8'hFF, "R7 byte 20 untouched", q, 8'hFF);
    rd(17'h21, 1'b0, q, drv);
    chk(q == 8'hFF, "R7 byte 21 untouched", q, 8'hFF);

    // R8 second strobe during a program
    n = 0;
    strobe(1'b0, 1'b1, 1'b0, 17'h22, 8'h0F);
    repeat (4) begin n++; @(negedge clk); end
    addr = 17'h23; data_in = 8'h00; wr_strb_n = 1'b0;
    n++;
    @(negedge clk);
    wr_strb_n = 1'b1;
    count_busy(n);
    chk(n == PROG_N, "R8 busy not extended", n, PROG_N);
    idle_pins();
    rd(17'h22, 1'b0, q, drv);
    chk(q == 8'h0F, "R8 first byte written", q, 8'h0F);
    rd(17'h23, 1'b0, q, drv);
    chk(q == 8'hFF, "R8 second strobe ignored", q, 8'hFF);

    // R9 abort in the middle
    strobe(1'b0, 1'b1, 1'b0, 17'h24, 8'h00);
    repeat (9) @(negedge clk);
    hv_ctl = 1'b0;
    @(negedge clk);
    chk(!busy, "R9 busy drops on abort", busy, 0);
    chk(err, "R9 err raised", err, 1);
    repeat (5) @(negedge clk);
    chk(err, "R9 err sticky", err, 1);
    idle_pins();
    rd(17'h24, 1'b0, q, drv);
    chk(q == 8'hFF, "R9 aborted byte untouched", q, 8'hFF);
    do_reset();
    chk(!err, "R9 err cleared by reset", err, 0);
    rd(17'h22, 1'b0, q, drv);
    chk(q == 8'h0F, "R2 array kept over reset", q, 8'h0F);

    // R9 abort on the same edge as completion
    strobe(1'b0, 1'b1, 1'b0, 17'h25, 8'h00);
    repeat (PROG_N - 1) @(negedge clk);
    hv_ctl = 1'b0;
    @(negedge clk);
    chk(!busy && err, "R9 final-edge abort", {busy, err}, 2'b01);
    idle_pins();
    rd(17'h25, 1'b0, q, drv);
    chk(q == 8'hFF, "R9 final-edge abort no write", q, 8'hFF);
    do_reset();

    // R9 erase abort by dropping the address-bit flag
    strobe(1'b0, 1'b1, 1'b1, '0, 8'h00);
    repeat (20) @(negedge clk);
    hv_sel = 1'b0;
    @(negedge clk);
    chk(!busy && err, "R9 erase abort", {busy, err}, 2'b01);
    idle_pins();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule